// File: doc/BRIEF.md
# Single-Position Shift and Rotate Unit

This block moves a data word by one bit position, left or right, in one of eight ways, and keeps a carry flip-flop. A 4-bit function code selects the operation. The result is produced combinationally from the operand, so it can feed a register-file write in the same cycle. The bit that leaves the word is captured in the carry flip-flop on the next rising clock edge.

Each operation differs only in the bit that enters the vacated end. That bit can be zero, the operand's sign bit, the bit leaving the opposite end, or the current carry. A small decoder turns the function code into a direction, an active strobe and one fill choice for each end. A datapath module applies these to the operand and updates the carry.

Top module: `shift_unit`

## Requirements
- R1: Function codes 0 and 9 through 15 put the operand on `result` unchanged.
- R2: Code 1 (logical right) gives `{0, operand[15:1]}`.
- R3: Code 2 (logical left) gives `{operand[14:0], 0}`.
- R4: Code 3 (arithmetic right) gives `{operand[15], operand[15:1]}`, so the sign bit is kept.
- R5: Code 4 (arithmetic left) gives `{operand[14:0], 0}`.
- R6: Code 5 (rotate right) gives `{operand[0], operand[15:1]}`.
- R7: Code 6 (rotate left) gives `{operand[14:0], operand[15]}`.
- R8: Code 7 (rotate right through carry) gives `{carryQ, operand[15:1]}`, using the carry value from before the clock edge.
- R9: Code 8 (rotate left through carry) gives `{operand[14:0], carryQ}`, using the carry value from before the clock edge.
- R10: On a rising clock edge with codes 1 to 8, `carryQ` takes `operand[15]` for the left codes (2, 4, 6, 8) and `operand[0]` for the right codes (1, 3, 5, 7).
- R11: On a rising clock edge with any other code, `carryQ` keeps its value.
- R12: While `rstN` is low, `carryQ` is 0. The reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the carry flip-flop updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the carry |
| fnSel | input | 4 | Function code |
| operand | input | 16 | Word to be shifted |
| result | output | 16 | Shifted word, combinational |
| carryQ | output | 1 | Carry flip-flop output |

## Verification
The assertions check four things on every cycle:
- the carry holds for inactive codes;
- the carry loads the correct end bit for left and right codes;
- the untouched bits of a right move are the upper operand bits;
- the through-carry rotates insert the live carry.

Only the scenarios show:
- the fill value of each individual operation, including the sign being kept on arithmetic right;
- the reserved codes passing the operand through;
- the carry chaining across back-to-back rotates through carry;
- the carry clearing when reset is asserted in the middle of a run.

// File: rtl/shift_pkg.sv
package shift_pkg;

  localparam logic [3:0] FN_PASS = 4'd0;
  localparam logic [3:0] FN_SRL  = 4'd1;
  localparam logic [3:0] FN_SLL  = 4'd2;
  localparam logic [3:0] FN_SRA  = 4'd3;
  localparam logic [3:0] FN_SLA  = 4'd4;
  localparam logic [3:0] FN_ROR  = 4'd5;
  localparam logic [3:0] FN_ROL  = 4'd6;
  localparam logic [3:0] FN_RRC  = 4'd7;
  localparam logic [3:0] FN_RLC  = 4'd8;

  // Which value enters a vacated end
  typedef enum logic [1:0] {
    FILL_ZERO  = 2'd0,
    FILL_SIGN  = 2'd1,
    FILL_WRAP  = 2'd2,
    FILL_CARRY = 2'd3
  } fillSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic     active;   // a shift or rotate code is selected
    logic     dirLeft;  // 1: move toward MSB, 0: toward LSB
    fillSel_e msbFill;  // fill choice for the MSB on right moves
    fillSel_e lsbFill;  // fill choice for the LSB on left moves
  } shiftCtrl_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] fnSel,
  output shiftCtrl_t ctrl
);

  always_comb begin
    ctrl = '{active: 1'b0, dirLeft: 1'b0, msbFill: FILL_ZERO, lsbFill: FILL_ZERO};
    case (fnSel)
      FN_SRL: begin ctrl.active = 1'b1; ctrl.msbFill = FILL_ZERO; end
      FN_SLL: begin ctrl.active = 1'b1; ctrl.dirLeft = 1'b1; ctrl.lsbFill = FILL_ZERO; end
      FN_SRA: begin ctrl.active = 1'b1; ctrl.msbFill = FILL_SIGN; end
      FN_SLA: begin ctrl.active = 1'b1; ctrl.dirLeft = 1'b1; ctrl.lsbFill = FILL_ZERO; end
      FN_ROR: begin ctrl.active = 1'b1; ctrl.msbFill = FILL_WRAP; end
      FN_ROL: begin ctrl.active = 1'b1; ctrl.dirLeft = 1'b1; ctrl.lsbFill = FILL_WRAP; end
      FN_RRC: begin ctrl.active = 1'b1; ctrl.msbFill = FILL_CARRY; end
      FN_RLC: begin ctrl.active = 1'b1; ctrl.dirLeft = 1'b1; ctrl.lsbFill = FILL_CARRY; end
      default: ;
    endcase
  end

  // Pass-through codes never raise the active strobe
  assert_pass_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (fnSel == FN_PASS || fnSel > FN_RLC) |-> !ctrl.active);

  // A left move never asks for a sign fill on the LSB
  assert_left_fill_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && ctrl.dirLeft) |-> ctrl.lsbFill != FILL_SIGN);

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftCtrl_t       ctrl,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] result,
  output logic             carryQ
);

  localparam int MSB = WIDTH - 1;

  logic msbIn;
  logic lsbIn;
  logic outBit;

  // Fill mux for the MSB end (used on right moves)
  always_comb begin
    case (ctrl.msbFill)
      FILL_ZERO:  msbIn = 1'b0;
      FILL_SIGN:  msbIn = operand[MSB];
      FILL_WRAP:  msbIn = operand[0];
      FILL_CARRY: msbIn = carryQ;
      default:    msbIn = 1'b0;
    endcase
  end

  // Fill mux for the LSB end (used on left moves); the sign slot is tied low
  always_comb begin
    case (ctrl.lsbFill)
      FILL_ZERO:  lsbIn = 1'b0;
      FILL_SIGN:  lsbIn = 1'b0;
      FILL_WRAP:  lsbIn = operand[MSB];
      FILL_CARRY: lsbIn = carryQ;
      default:    lsbIn = 1'b0;
    endcase
  end

  // Shifter core
  always_comb begin
    if (!ctrl.active)     result = operand;
    else if (ctrl.dirLeft) result = {operand[MSB-1:0], lsbIn};
    else                   result = {msbIn, operand[MSB:1]};
  end

  // Carry source select: the end bit that leaves the word
  assign outBit = ctrl.dirLeft ? operand[MSB] : operand[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            carryQ <= 1'b0;
    else if (ctrl.active) carryQ <= outBit;
  end

  assert_carry_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.active |=> $stable(carryQ));

  assert_carry_left_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && ctrl.dirLeft) |=> carryQ == $past(operand[MSB]));

  assert_carry_right_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && !ctrl.dirLeft) |=> carryQ == $past(operand[0]));

  assert_right_body_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && !ctrl.dirLeft) |-> result[MSB-1:0] == operand[MSB:1]);

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       fnSel,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] result,
  output logic             carryQ
);

  shiftCtrl_t ctrl;

  shift_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .fnSel (fnSel),
    .ctrl  (ctrl)
  );

  shift_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .operand (operand),
    .result  (result),
    .carryQ  (carryQ)
  );

  assert_rrc_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fnSel == FN_RRC) |-> result[WIDTH-1] == carryQ);

  assert_rlc_fill_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fnSel == FN_RLC) |-> result[0] == carryQ);

endmodule

// File: tb/shift_unit_test.sv
`timescale 1ns/1ps
module shift_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  fnSel = 4'd0;
  logic [15:0] operand = 16'h0;
  logic [15:0] result;
  logic        carryQ;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [15:0] expResult;
    logic        expCarry;
    string       resTag;
    string       carryTag;
  } item_t;

  item_t sbQ[$];
  logic  modelCarry = 1'b0;
  logic  nextCarry = 1'b0;
  string nextCarryTag = "R12";

  always #2.5 clk = ~clk;

  shift_unit uut (
    .clk(clk), .rstN(rstN), .fnSel(fnSel),
    .operand(operand), .result(result), .carryQ(carryQ)
  );

  // Driver: applies one operation and pushes the expectation
  task automatic apply(input logic [3:0] fn, input logic [15:0] op, input string tag);
    item_t it;
    logic [15:0] r;
    logic nc;
    @(posedge clk); #1;
    modelCarry = nextCarry;
    fnSel = fn;
    operand = op;
    nc = modelCarry;
    case (fn)
      4'd1: begin r = op >> 1;                          nc = op[0];  end
      4'd2: begin r = op << 1;                          nc = op[15]; end
      4'd3: begin r = {op[15], op[15:1]};               nc = op[0];  end
      4'd4: begin r = op << 1;                          nc = op[15]; end
      4'd5: begin r = {op[0], op[15:1]};                nc = op[0];  end
      4'd6: begin r = {op[14:0], op[15]};               nc = op[15]; end
      4'd7: begin r = {modelCarry, op[15:1]};           nc = op[0];  end
      4'd8: begin r = {op[14:0], modelCarry};           nc = op[15]; end
      default: r = op;
    endcase
    it.expResult = r;
    it.expCarry  = modelCarry;
    it.resTag    = tag;
    it.carryTag  = nextCarryTag;
    sbQ.push_back(it);
    nextCarry    = nc;
    nextCarryTag = (fn >= 4'd1 && fn <= 4'd8) ? "R10" : "R11";
  endtask

  // Monitor: compares mid-cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        checks++;
        if (result !== it.expResult) begin
          failures++;
          $display("FAIL %s result got %h expected %h", it.resTag, result, it.expResult);
        end
        checks++;
        if (carryQ !== it.expCarry) begin
          failures++;
          $display("FAIL %s carry got %b expected %b", it.carryTag, carryQ, it.expCarry);
        end
      end
    end
  end

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (carryQ !== 1'b0) begin
      failures++;
      $display("FAIL R12 carry in reset got %b expected 0", carryQ);
    end
    rstN = 1'b1;

    apply(4'd0,  16'hA5C3, "R1");
    apply(4'd1,  16'h8001, "R2");
    apply(4'd1,  16'h7FFE, "R2");
    apply(4'd2,  16'h8001, "R3");
    apply(4'd2,  16'h4000, "R3");
    apply(4'd3,  16'h8002, "R4");
    apply(4'd3,  16'h4003, "R4");
    apply(4'd4,  16'hC001, "R5");
    apply(4'd4,  16'h0001, "R5");
    apply(4'd5,  16'h0001, "R6");
    apply(4'd5,  16'h1234, "R6");
    apply(4'd6,  16'h8000, "R7");
    apply(4'd6,  16'h4321, "R7");
    apply(4'd9,  16'hFFFF, "R1");
    apply(4'd15, 16'h0F0F, "R11");
    apply(4'd2,  16'h8000, "R3");
    apply(4'd7,  16'h0002, "R8");
    apply(4'd7,  16'h0003, "R8");
    apply(4'd7,  16'hFFFE, "R8");
    apply(4'd8,  16'h8000, "R9");
    apply(4'd8,  16'h0000, "R9");
    apply(4'd8,  16'h7FFF, "R9");
    apply(4'd12, 16'h1111, "R11");
    apply(4'd0,  16'h2222, "R11");
    apply(4'd8,  16'h8000, "R9");
    apply(4'd0,  16'h0000, "R10");

    // Reset in mid-run clears the carry
    @(posedge clk); #1;
    rstN = 1'b0;
    #1;
    checks++;
    if (carryQ !== 1'b0) begin
      failures++;
      $display("FAIL R12 carry after reset got %b expected 0", carryQ);
    end
    @(posedge clk); #1;
    rstN = 1'b1;
    nextCarry = 1'b0;
    nextCarryTag = "R12";
    apply(4'd9, 16'h5555, "R1");
    apply(4'd7, 16'h0000, "R8");

    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule